// File: doc/BRIEF.md
# Bus Wait State Generator

This block paces a processor bus cycle through its four phases and stretches the cycle for slow memories and peripherals. A cycle begins when a start strobe is seen while the block is idle. The phases then run T1, T2, one or more T3, and T4. The block slows the cycle down by repeating T3. The address side of the bus treats T1 as the point where the address becomes valid. The data side captures read data on entry to T4.

Several chip-select regions share one generator. Each region supplies two settings: a 4-bit count of extra T3 states, and a bit that says whether the external READY line must also agree before the cycle may finish. Both settings are captured for the selected region when the cycle starts and hold until the cycle ends. The block reports the current phase and raises a done pulse for the one clock of T4. A start strobe present in T4 chains a new cycle with no idle clock between the two.

Top module: `wsg_top`

## Requirements
- R1: While rst_ni is low, phase_o reads 0 (idle) and done_o is 0, and the wait counter is cleared. Asserting reset in the middle of a cycle forces idle at once.
- R2: phase_o encodes idle=0, T1=1, T2=2, T3=3, T4=4. A start_i sampled high on a rising edge while idle makes phase_o read 1 after that edge.
- R3: With a wait count of 0 and READY not required, each of T1, T2, T3 and T4 lasts exactly one clock.
- R4: Region r takes its wait count N from wait_cfg_i[4r+3:4r]. With READY not required, T3 lasts N+1 clocks, and the counter drops by one on each T3 clock while it is nonzero.
- R5: The count and the READY mode are taken from the region given by region_sel_i on the edge that starts the cycle. Changes to region_sel_i, wait_cfg_i or rdy_req_i later in that cycle do not change its length.
- R6: When bit r of rdy_req_i is 1, the cycle stays in T3 until the programmed waits have run out and ready_i is high on a rising edge during T3. If ready_i first reads high on the D-th T3 edge (counting from 0), T3 lasts max(N,D)+1 clocks.
- R7: ready_i is sampled only on edges during T3. A high level during T1 or T2 does not shorten the cycle. With bit r of rdy_req_i at 0, a ready_i that stays low does not lengthen the cycle.
- R8: done_o is high exactly while phase_o is 4, which is one clock per cycle.
- R9: After T4 the block returns to idle when start_i is low. When start_i is high in T4, the next clock is T1 of a new cycle, using the newly selected region.
- R10: start_i during T1, T2 or T3 is ignored: it neither restarts nor extends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Cycle start strobe |
| region_sel_i | input | RSEL_W (2) | Active chip-select region |
| wait_cfg_i | input | NUM_REGIONS*WAIT_W (16) | Packed per-region wait counts |
| rdy_req_i | input | NUM_REGIONS (4) | Per-region: 1 = READY must be high to finish |
| ready_i | input | 1 | External READY line |
| phase_o | output | 3 | Current phase code |
| done_o | output | 1 | High during T4 |

## Verification
The programmed waits running out and READY arriving can fall on the same T3 edge, and the cycle must finish on exactly that edge. The bench sweeps every wait count in every region against READY that is ready at once, arrives earlier than the count, arrives later than the count, or, in the ignored mode, never arrives. Each time it compares the measured T3 length with max(N,D)+1 or N+1. A second collision is a new start strobe arriving in T4 while the done pulse is up. This is provoked back to back, and the bench judges it by the phase reading T1 on the very next clock.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;
endpackage

// File: rtl/wsg_cfg_sel.sv
module wsg_cfg_sel #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 4,
  localparam int RSEL_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [RSEL_W-1:0]             region_sel_i,
  input  logic [NUM_REGIONS*WAIT_W-1:0] wait_cfg_i,
  input  logic [NUM_REGIONS-1:0]        rdy_req_i,
  output logic [WAIT_W-1:0]             waits_o,
  output logic                          rdy_req_o
);
  logic [WAIT_W-1:0]      waits_a [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    assign waits_a[g] = wait_cfg_i[g*WAIT_W +: WAIT_W];
    assign hit[g]     = (region_sel_i == RSEL_W'(g));
  end

  // one-hot AND-OR mux; an unmapped select yields zero waits, READY ignored
  always_comb begin
    waits_o   = '0;
    rdy_req_o = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) begin
        waits_o   = waits_o | waits_a[i];
        rdy_req_o = rdy_req_o | rdy_req_i[i];
      end
    end
  end
endmodule

// File: rtl/wsg_wait_ctr.sv
module wsg_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic [WAIT_W-1:0] cnt_o,
  output logic              zero_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (dec_i && (cnt_q != '0))  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wsg_phase_fsm.sv
module wsg_phase_fsm
  import wsg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   zero_i,
  input  logic   rdy_req_i,
  input  logic   ready_i,
  output phase_e phase_o,
  output logic   load_o,
  output logic   dec_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    case (state_q)
      PH_IDLE: if (start_i) begin
        state_d = PH_T1;
        load_o  = 1'b1;
      end
      PH_T1: state_d = PH_T2;
      PH_T2: state_d = PH_T3;
      PH_T3: begin
        // leave only when waits are spent and READY agrees (if required)
        if (zero_i && (!rdy_req_i || ready_i)) state_d = PH_T4;
        else                                   dec_o   = !zero_i;
      end
      PH_T4: if (start_i) begin
        state_d = PH_T1;
        load_o  = 1'b1;
      end else begin
        state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_IDLE;
    else         state_q <= state_d;
  end

  assign phase_o = state_q;
endmodule

// File: rtl/wsg_top.sv
module wsg_top
  import wsg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 4,
  localparam int RSEL_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [RSEL_W-1:0]             region_sel_i,
  input  logic [NUM_REGIONS*WAIT_W-1:0] wait_cfg_i,
  input  logic [NUM_REGIONS-1:0]        rdy_req_i,
  input  logic                          ready_i,
  output logic [2:0]                    phase_o,
  output logic                          done_o
);
  logic [WAIT_W-1:0] sel_waits;
  logic              sel_rdy_req;
  logic              rdy_req_q;
  logic              load, dec, zero;
  logic [WAIT_W-1:0] wait_cnt;
  phase_e            phase;

  wsg_cfg_sel #(.NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W)) u_sel (
    .region_sel_i (region_sel_i),
    .wait_cfg_i   (wait_cfg_i),
    .rdy_req_i    (rdy_req_i),
    .waits_o      (sel_waits),
    .rdy_req_o    (sel_rdy_req)
  );

  wsg_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (sel_waits),
    .dec_i      (dec),
    .cnt_o      (wait_cnt),
    .zero_o     (zero)
  );

  // READY mode frozen for the whole cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdy_req_q <= 1'b0;
    else if (load) rdy_req_q <= sel_rdy_req;
  end

  wsg_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .zero_i    (zero),
    .rdy_req_i (rdy_req_q),
    .ready_i   (ready_i),
    .phase_o   (phase),
    .load_o    (load),
    .dec_o     (dec)
  );

  assign phase_o = phase;
  assign done_o  = (phase == PH_T4);
endmodule

// File: rtl/wsg_chk.sv
module wsg_chk #(
  parameter int WAIT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_i,
  input logic [2:0]        phase_o,
  input logic              done_o,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic              rdy_req_q
);
  assert_t1_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd1 |=> phase_o == 3'd2);

  assert_t2_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd2 |=> phase_o == 3'd3);

  assert_wait_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3 && wait_cnt != '0) |=> phase_o == 3'd3);

  assert_wait_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3 && wait_cnt != '0) |=>
      wait_cnt == $past(wait_cnt) - {{(WAIT_W-1){1'b0}}, 1'b1});

  assert_ready_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3 && rdy_req_q && !ready_i) |=> phase_o == 3'd3);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_t4_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd4 |=> (start_i ? 1'b1 : 1'b1) && (phase_o == 3'd1 || phase_o == 3'd0));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 && !start_i) |=> phase_o == 3'd0);

  assert_idle_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 && start_i) |=> phase_o == 3'd1);

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= 3'd4);
endmodule

bind wsg_top wsg_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_i   (ready_i),
  .phase_o   (phase_o),
  .done_o    (done_o),
  .wait_cnt  (wait_cnt),
  .rdy_req_q (rdy_req_q)
);

// File: tb/sim_wsg_top.sv
module sim_wsg_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int WW = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [1:0]      region_sel_i = '0;
  logic [NREG*WW-1:0] wait_cfg_i = '0;
  logic [NREG-1:0] rdy_req_i = '0;
  logic            ready_i = 1'b0;
  logic [2:0]      phase_o;
  logic            done_o;

  int checks = 0;
  int errors = 0;

  wsg_top #(.NUM_REGIONS(NREG), .WAIT_W(WW)) u0 (
    .clk_i, .rst_ni, .start_i, .region_sel_i, .wait_cfg_i,
    .rdy_req_i, .ready_i, .phase_o, .done_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a cycle at the next edge; returns edges from start edge until done seen.
  // mid: 0 none, 1 scramble config + stray start in T2, 2 ready pulse in T1/T2
  task automatic run_cycle(input int r, input int d, input int mid, output int edges);
    logic [NREG*WW-1:0] cfg_save;
    logic [NREG-1:0]    rdy_save;
    cfg_save = wait_cfg_i;
    rdy_save = rdy_req_i;
    region_sel_i = 2'(r);
    start_i = 1'b1;
    ready_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    edges = 0;
    while (edges < 60) begin
      ready_i = ((edges + 1) >= (3 + d));
      start_i = 1'b0;
      if (mid == 1 && edges == 1) begin
        wait_cfg_i   = ~cfg_save;
        rdy_req_i    = ~rdy_save;
        region_sel_i = 2'(r + 1);
        start_i      = 1'b1;
      end
      if (mid == 2 && edges < 2) ready_i = 1'b1;
      @(posedge clk_i);
      edges++;
      @(negedge clk_i);
      if (done_o) break;
    end
    start_i = 1'b0;
    wait_cfg_i = cfg_save;
    rdy_req_i = rdy_save;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int edges;
    // R1: reset state
    #(CLK_PERIOD*2 + 1);
    chk(phase_o == 3'd0, "R1 phase in reset", int'(phase_o), 0);
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(phase_o == 3'd0, "R1 idle after reset", int'(phase_o), 0);

    // R2/R3: zero-wait cycle, phase trace
    wait_cfg_i = '0;
    rdy_req_i = '0;
    region_sel_i = 2'd0;
    start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    chk(phase_o == 3'd1, "R2 T1 after start", int'(phase_o), 1);
    @(posedge clk_i); @(negedge clk_i);
    chk(phase_o == 3'd2, "R3 T2", int'(phase_o), 2);
    @(posedge clk_i); @(negedge clk_i);
    chk(phase_o == 3'd3, "R3 T3", int'(phase_o), 3);
    @(posedge clk_i); @(negedge clk_i);
    chk(phase_o == 3'd4 && done_o, "R3 R8 T4 with done", int'(phase_o), 4);
    @(posedge clk_i); @(negedge clk_i);
    chk(phase_o == 3'd0 && !done_o, "R9 back to idle", int'(phase_o), 0);

    // R4 R5 R6 R7 R10: sweep counts, regions, modes, READY arrival
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 2; m++) begin
        for (int q = 0; q < NREG; q++) begin
          wait_cfg_i[q*WW +: WW] = 4'((n + 5*q) % 16);
          rdy_req_i[q] = 1'(m ^ (q & 1));
        end
        for (int r = 0; r < NREG; r++) begin
          for (int di = 0; di < 3; di++) begin
            int nw, dv, kexp, mid;
            bit req;
            nw  = (n + 5*r) % 16;
            req = 1'(m ^ (r & 1));
            dv  = (di == 0) ? 0 : (di == 1) ? 6 : 19;
            if (!req && di == 2) dv = 99;
            kexp = req ? ((nw > dv) ? nw : dv) : nw;
            mid  = (n + di + r) % 3;
            run_cycle(r, dv, mid, edges);
            if (req) chk(edges == 3 + kexp, "R6 T3 length with READY", edges, 3 + kexp);
            else     chk(edges == 3 + kexp, "R4 R7 T3 length READY ignored", edges, 3 + kexp);
            if (mid == 1) chk(edges == 3 + kexp, "R5 R10 mid-cycle changes ignored", edges, 3 + kexp);
            chk(phase_o == 3'd4 && done_o, "R8 done in T4", int'(phase_o), 4);
            @(posedge clk_i); @(negedge clk_i);
            chk(phase_o == 3'd0 && !done_o, "R9 idle after T4", int'(phase_o), 0);
          end
        end
      end
    end

    // R9: back-to-back cycle, new region used
    wait_cfg_i = '0;
    wait_cfg_i[3:0] = 4'd2;
    rdy_req_i = '0;
    run_cycle(0, 99, 0, edges);
    chk(edges == 5, "R4 region0 two waits", edges, 5);
    region_sel_i = 2'd1;
    start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    chk(phase_o == 3'd1, "R9 T4 straight to T1", int'(phase_o), 1);
    edges = 0;
    while (edges < 60) begin
      @(posedge clk_i); edges++; @(negedge clk_i);
      if (done_o) break;
    end
    chk(edges == 3, "R9 chained cycle uses new region", edges, 3);
    @(posedge clk_i); @(negedge clk_i);

    // R1: reset mid-cycle
    wait_cfg_i[3:0] = 4'd9;
    region_sel_i = 2'd0;
    start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) begin @(posedge clk_i); @(negedge clk_i); end
    chk(phase_o == 3'd3, "R4 in T3 before reset", int'(phase_o), 3);
    rst_ni = 1'b0;
    #1;
    chk(phase_o == 3'd0 && !done_o, "R1 async reset to idle", int'(phase_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // counter cleared: zero-wait region runs 4 clocks after reset
    wait_cfg_i = '0;
    run_cycle(0, 99, 0, edges);
    chk(edges == 3, "R1 counter cleared by reset", edges, 3);
    @(posedge clk_i); @(negedge clk_i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule